// File: doc/BRIEF.md
# Cache Block Refill Controller

This block serves one cache miss at a time by fetching a four-word block from a memory model that it contains. A compile-time choice picks one of three memory organizations: a memory one word wide that is accessed four times in turn, a wider memory that moves two or four words per access, or four banks that are accessed side by side and then return their words one after another. The block reproduces the refill latency of the selected organization exactly. The timing rules are one cycle to send the address, fifteen cycles for each memory access, and one cycle for each bus transfer.

The cache side raises a request with a word address while the controller is ready. The controller ignores the two low address bits and fetches the enclosing aligned block. Each word arrives on its own lane of a block-wide data bus, and a per-lane valid bit marks it. A done pulse marks the final transfer. A penalty output then shows how many cycles the refill took. The memory model is read-only, and its word at word address A holds {8'h5A, A[7:0], 8'hC3, ~A[7:0]}.

Top module: `blk_refill_ctrl`

## Requirements
- R1: After reset, ready is 1, and word_valid, done and penalty are 0. A request is taken only on an edge where ready is 1. Ready is 0 from the next cycle through the done cycle, and it is 1 again in the cycle after done.
- R2: In the one-word-wide organization, done is high in cycle 65 after acceptance. Cycle 1 is the cycle that follows the accepting edge.
- R3: In the wide organization, done falls in cycle 33 with two words per access and in cycle 17 with four words per access.
- R4: In the banked organization, done falls in cycle 20, and one word arrives in each of cycles 17 to 20.
- R5: Every lane is valid exactly once per refill, in ascending lane order. Each transfer cycle carries one lane in the one-word and banked organizations, and two or four adjacent lanes in the wide organization.
- R6: Lane k (bits 32k+31..32k) carries the memory word at word address 4*floor(A/4)+k, where A is the request address.
- R7: The two low bits of the request address have no effect on which block is returned.
- R8: A request raised while a refill runs has no effect: the running refill returns its own block with its own latency, and no further refill starts once the request is dropped.
- R9: penalty shows the cycle count of the last finished refill from the cycle after its done pulse, and holds that value until another refill finishes.
- R10: done is high for a single cycle, and that cycle is the one in which the highest lane is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Refill request, taken when ready is high |
| req_addr | input | 8 | Word address of the missing word |
| ready | output | 1 | Controller idle and able to take a request |
| blk_data | output | 128 | Four word lanes; lane k in bits 32k+31..32k |
| word_valid | output | 4 | Per-lane valid, high for the cycle its word is delivered |
| done | output | 1 | High in the final transfer cycle of a refill |
| penalty | output | 8 | Cycle count of the last finished refill |

## Verification
Three events share the final cycle of a refill: the done pulse, the delivery of the highest lane, and the latch of the cycle count. In that same cycle the controller is about to become ready again. The bench checks the first two together by sampling every cycle of a refill in all four configurations. It then reads the count in the following cycle and compares it with 65, 33, 17 or 20. A back-to-back case holds the request high through the done cycle, so that the second refill is taken on the first edge where ready is high again. The bench judges that case by ready falling exactly one cycle later and by the second block's own latency and data.

// File: rtl/refill_pkg.sv
package refill_pkg;

  typedef enum logic [1:0] {
    ORG_SEQ    = 2'd0,
    ORG_WIDE   = 2'd1,
    ORG_BANKED = 2'd2
  } org_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_ADDR, ST_ACC, ST_XFER
  } phase_e;

  // words moved per bus transfer
  function automatic int words_per_xfer(org_e org, int bus_w);
    return (org == ORG_WIDE) ? bus_w : 1;
  endfunction

  // number of memory access rounds per block
  function automatic int access_rounds(org_e org, int bus_w, int lanes);
    return (org == ORG_BANKED) ? 1 : lanes / words_per_xfer(org, bus_w);
  endfunction

  // bus transfers after each access round
  function automatic int xfers_per_round(org_e org, int lanes);
    return (org == ORG_BANKED) ? lanes : 1;
  endfunction

  function automatic int refill_cycles(org_e org, int bus_w, int lanes,
                                       int acc_cyc, int addr_cyc);
    return addr_cyc + access_rounds(org, bus_w, lanes) *
           (acc_cyc + xfers_per_round(org, lanes));
  endfunction

  // preset content of the memory model
  function automatic logic [31:0] fill_word(input int a);
    logic [7:0] b;
    b = a[7:0];
    return {8'h5A, b, 8'hC3, ~b};
  endfunction

endpackage

// File: rtl/refill_bank.sv
module refill_bank #(
  parameter int WORD_W  = 32,
  parameter int IDX_W   = 6,
  parameter int LANES   = 4,
  parameter int BANK_ID = 0
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  ridx,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem[i] = WORD_W'(refill_pkg::fill_word(i * LANES + BANK_ID));
  end

  // registered read port, no reset, so it maps onto block RAM
  always_ff @(posedge clk) rdata <= mem[ridx];

endmodule

// File: rtl/refill_seq.sv
module refill_seq
  import refill_pkg::*;
#(
  parameter org_e ORG      = ORG_SEQ,
  parameter int   BUS_W    = 2,
  parameter int   LANES    = 4,
  parameter int   ACC_CYC  = 15,
  parameter int   ADDR_CYC = 1,
  parameter int   IDX_W    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [IDX_W-1:0] blk_idx,
  output logic             ready,
  output logic             done,
  output logic [LANES-1:0] lane_valid,
  output logic [IDX_W-1:0] base
);
  localparam int WPX  = words_per_xfer(ORG, BUS_W);
  localparam int NGRP = access_rounds(ORG, BUS_W, LANES);
  localparam int XPG  = xfers_per_round(ORG, LANES);
  localparam int CW   = $clog2(ACC_CYC + ADDR_CYC + LANES + 1);
  localparam int GW   = $clog2(LANES) + 1;
  localparam int WX   = $clog2(LANES) + 1;

  phase_e        state;
  logic [CW-1:0] cnt;
  logic [GW-1:0] grp;
  logic [WX-1:0] widx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      grp   <= '0;
      widx  <= '0;
      base  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req) begin
          state <= ST_ADDR;
          base  <= blk_idx;
          cnt   <= '0;
          grp   <= '0;
          widx  <= '0;
        end
        ST_ADDR: begin
          if (cnt == CW'(ADDR_CYC - 1)) begin
            state <= ST_ACC;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_ACC: begin
          if (cnt == CW'(ACC_CYC - 1)) begin
            state <= ST_XFER;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_XFER: begin
          widx <= widx + WX'(WPX);
          if (cnt == CW'(XPG - 1)) begin
            cnt <= '0;
            if (grp == GW'(NGRP - 1)) state <= ST_IDLE;
            else begin
              grp   <= grp + 1'b1;
              state <= ST_ACC;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ready = (state == ST_IDLE);
  assign done  = (state == ST_XFER) && (cnt == CW'(XPG - 1)) &&
                 (grp == GW'(NGRP - 1));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_valid[l] = (state == ST_XFER) && (WX'(l) >= widx) &&
                           (WX'(l) < widx + WX'(WPX));
  end

  // R1: leaving idle only happens on a request
  a_r1_accept_only_on_req: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_IDLE && state == ST_ADDR) |-> $past(req));

  // R5: every transfer cycle carries the organization's lane count
  a_r5_lanes_per_xfer: assert property (@(posedge clk) disable iff (rst)
    (state == ST_XFER) |-> ($countones(lane_valid) == WPX));

  // R8: block base is frozen while a refill runs
  a_r8_base_frozen: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(base));

  // R10: done marks the cycle of the highest lane
  a_r10_done_with_last_lane: assert property (@(posedge clk) disable iff (rst)
    done |-> lane_valid[LANES-1]);

endmodule

// File: rtl/refill_penalty.sv
module refill_penalty #(
  parameter int PEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             done,
  output logic [PEN_W-1:0] penalty
);
  logic [PEN_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      penalty <= '0;
    end else if (start) begin
      run_cnt <= PEN_W'(1);
    end else if (done) begin
      penalty <= run_cnt;
      run_cnt <= '0;
    end else if (run_cnt != '0) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // R9: the reported figure moves only after a done pulse
  a_r9_penalty_held: assert property (@(posedge clk) disable iff (rst)
    !$past(done) |-> $stable(penalty));

endmodule

// File: rtl/blk_refill_ctrl.sv
module blk_refill_ctrl
  import refill_pkg::*;
#(
  parameter org_e ORG      = ORG_SEQ,
  parameter int   BUS_W    = 2,
  parameter int   WORD_W   = 32,
  parameter int   ADDR_W   = 8,
  parameter int   LANES    = 4,
  parameter int   ACC_CYC  = 15,
  parameter int   ADDR_CYC = 1,
  parameter int   PEN_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req,
  input  logic [ADDR_W-1:0]       req_addr,
  output logic                    ready,
  output logic [LANES*WORD_W-1:0] blk_data,
  output logic [LANES-1:0]        word_valid,
  output logic                    done,
  output logic [PEN_W-1:0]        penalty
);
  localparam int LW      = $clog2(LANES);
  localparam int IDX_W   = ADDR_W - LW;
  localparam int PEN_EXP = refill_cycles(ORG, BUS_W, LANES, ACC_CYC, ADDR_CYC);

  logic [IDX_W-1:0] base;
  logic             addr_lo_unused;

  assign addr_lo_unused = ^req_addr[LW-1:0];

  refill_seq #(
    .ORG(ORG), .BUS_W(BUS_W), .LANES(LANES), .ACC_CYC(ACC_CYC),
    .ADDR_CYC(ADDR_CYC), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst(rst), .req(req), .blk_idx(req_addr[ADDR_W-1:LW]),
    .ready(ready), .done(done), .lane_valid(word_valid), .base(base)
  );

  refill_penalty #(.PEN_W(PEN_W)) u_pen (
    .clk(clk), .rst(rst), .start(ready && req), .done(done),
    .penalty(penalty)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    refill_bank #(
      .WORD_W(WORD_W), .IDX_W(IDX_W), .LANES(LANES), .BANK_ID(b)
    ) u_bank (
      .clk(clk), .ridx(base), .rdata(blk_data[b*WORD_W +: WORD_W])
    );
  end

  // R2, R3, R4: the reported figure equals the organization's latency
  a_r2_penalty_figure: assert property (@(posedge clk) disable iff (rst)
    done |=> (penalty == PEN_W'(PEN_EXP)));

endmodule

// File: tb/test_blk_refill_ctrl.sv
`timescale 1ns/1ps
module test_blk_refill_ctrl;
  import refill_pkg::*;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_a   [4];
  logic [7:0]   addr_a  [4];
  logic         rdy_a   [4];
  logic         done_a  [4];
  logic [3:0]   wv_a    [4];
  logic [127:0] dat_a   [4];
  logic [7:0]   pen_a   [4];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  blk_refill_ctrl #(.ORG(ORG_SEQ)) i_blk_refill_ctrl (
    .clk(clk), .rst(rst), .req(req_a[0]), .req_addr(addr_a[0]),
    .ready(rdy_a[0]), .blk_data(dat_a[0]), .word_valid(wv_a[0]),
    .done(done_a[0]), .penalty(pen_a[0]));
  blk_refill_ctrl #(.ORG(ORG_WIDE), .BUS_W(2)) i_blk_refill_ctrl_w2 (
    .clk(clk), .rst(rst), .req(req_a[1]), .req_addr(addr_a[1]),
    .ready(rdy_a[1]), .blk_data(dat_a[1]), .word_valid(wv_a[1]),
    .done(done_a[1]), .penalty(pen_a[1]));
  blk_refill_ctrl #(.ORG(ORG_WIDE), .BUS_W(4)) i_blk_refill_ctrl_w4 (
    .clk(clk), .rst(rst), .req(req_a[2]), .req_addr(addr_a[2]),
    .ready(rdy_a[2]), .blk_data(dat_a[2]), .word_valid(wv_a[2]),
    .done(done_a[2]), .penalty(pen_a[2]));
  blk_refill_ctrl #(.ORG(ORG_BANKED)) i_blk_refill_ctrl_bk (
    .clk(clk), .rst(rst), .req(req_a[3]), .req_addr(addr_a[3]),
    .ready(rdy_a[3]), .blk_data(dat_a[3]), .word_valid(wv_a[3]),
    .done(done_a[3]), .penalty(pen_a[3]));

  // {config, address, expected cycles}
  localparam logic [17:0] VEC [8] = '{
    {2'd0, 8'h00, 8'd65}, {2'd1, 8'h14, 8'd33},
    {2'd2, 8'h28, 8'd17}, {2'd3, 8'h3C, 8'd20},
    {2'd0, 8'hFD, 8'd65}, {2'd1, 8'h81, 8'd33},
    {2'd2, 8'h43, 8'd17}, {2'd3, 8'hC6, 8'd20}
  };

  function automatic logic [31:0] exp_word(input logic [7:0] a);
    return {8'h5A, a, 8'hC3, ~a};
  endfunction

  function automatic string lat_tag(input int k);
    return (k == 0) ? "R2" : (k == 3) ? "R4" : "R3";
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Follows one refill from the current negedge onward; cyc counts cycles
  // since the accepting edge.
  task automatic follow(input int k, input logic [7:0] a, input int exp,
                        input bit poke);
    logic [7:0] blk;
    bit [3:0]   seen;
    int         hi;
    int         cyc;
    int         per;
    blk  = {a[7:2], 2'b00};
    seen = '0;
    hi   = -1;
    cyc  = 1;
    per  = (k == 1) ? 2 : (k == 2) ? 4 : 1;
    for (int guard = 0; guard < 200; guard++) begin
      int n;
      int top;
      if (poke && cyc == 4) begin req_a[k] = 1'b1; addr_a[k] = a + 8'h20; end
      if (poke && cyc == 7) req_a[k] = 1'b0;
      chk(rdy_a[k] == 1'b0, "R1 ready low in refill", rdy_a[k], 0);
      n   = 0;
      top = hi;
      for (int l = 0; l < 4; l++) begin
        if (wv_a[k][l]) begin
          n++;
          chk(!seen[l] && l > hi, "R5 lane once, ascending", l, hi + 1);
          chk(dat_a[k][l*32 +: 32] == exp_word(8'(blk + l)),
              "R6 lane data", dat_a[k][l*32 +: 32], exp_word(8'(blk + l)));
          seen[l] = 1'b1;
          top = l;
        end
      end
      hi = top;
      if (n != 0) chk(n == per, "R5 lanes per transfer", n, per);
      if (k == 3 && n != 0) chk(cyc >= 17, "R4 word slot", cyc, 17);
      if (done_a[k]) begin
        chk(cyc == exp, lat_tag(k), cyc, exp);
        chk(seen == 4'hF, "R5 all lanes", seen, 4'hF);
        chk(wv_a[k][3], "R10 done with last lane", wv_a[k], 4'h8);
        break;
      end
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_refill(input int k, input logic [7:0] a, input int exp,
                            input bit poke);
    @(negedge clk);
    chk(rdy_a[k] == 1'b1, "R1 ready before request", rdy_a[k], 1);
    req_a[k]  = 1'b1;
    addr_a[k] = a;
    @(negedge clk);
    req_a[k] = 1'b0;
    follow(k, a, exp, poke);
    @(negedge clk);
    chk(rdy_a[k] == 1'b1, poke ? "R8 no extra refill" : "R1 ready after done",
        rdy_a[k], 1);
    chk(done_a[k] == 1'b0, "R10 single-cycle done", done_a[k], 0);
    chk(pen_a[k] == 8'(exp), "R9 penalty figure", pen_a[k], exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin req_a[k] = 1'b0; addr_a[k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk(rdy_a[k] == 1'b1, "R1 reset ready", rdy_a[k], 1);
      chk(wv_a[k] == 4'h0 && done_a[k] == 1'b0, "R1 reset idle outputs",
          {wv_a[k], done_a[k]}, 0);
      chk(pen_a[k] == 8'h00, "R1 reset penalty", pen_a[k], 0);
    end

    // table walk; entries 4..7 use unaligned addresses (R7)
    for (int v = 0; v < 8; v++)
      run_refill(int'(VEC[v][17:16]), VEC[v][15:8], int'(VEC[v][7:0]), 1'b0);

    // R9: the figure holds while idle
    repeat (4) @(negedge clk);
    chk(pen_a[0] == 8'd65, "R9 penalty held", pen_a[0], 65);

    // R8: request raised mid-refill on each organization
    for (int k = 0; k < 4; k++)
      run_refill(k, 8'h52, (k == 0) ? 65 : (k == 1) ? 33 : (k == 2) ? 17 : 20,
                 1'b1);

    // R1: back-to-back, request held through the done cycle
    @(negedge clk);
    req_a[3]  = 1'b1;
    addr_a[3] = 8'h10;
    @(negedge clk);
    for (int g = 0; g < 100 && !done_a[3]; g++) @(negedge clk);
    addr_a[3] = 8'h24;
    @(negedge clk);
    chk(rdy_a[3] == 1'b1, "R1 ready after done (back-to-back)", rdy_a[3], 1);
    @(negedge clk);
    req_a[3] = 1'b0;
    chk(rdy_a[3] == 1'b0, "R1 second request taken at once", rdy_a[3], 0);
    follow(3, 8'h24, 20, 1'b0);
    @(negedge clk);
    chk(pen_a[3] == 8'd20, "R9 penalty after back-to-back", pen_a[3], 20);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule